// File: doc/BRIEF.md
# Peripheral Clock-Gate and Reset Controller

This block keeps the clock-enable and reset state for up to 48 peripheral slots, arranged as three groups of 16: an interconnect group, a fast-bridge group and a slow-bridge group. Software turns a clock on by writing a peripheral code to a set register and turns it off by writing the same code to a clear register. Each group has a readable enable-status word and a read/write reset word. Every slot drives one clock-enable output and one reset output. A glitch-free gating cell and the bus protocol sit outside.

Some clocks are owned by hardware and follow a request input rather than software. Two slots have no enable control and always report enabled. The primary console UART cannot be gated off, and once its reset is released it cannot be put back into reset. Every peripheral comes out of power-up held in reset with its software clock off. Releasing reset and enabling the clock are separate steps.

Top module: `periph_gate_ctrl`

## Requirements
- R1: After reset, every present peripheral has its reset output high, every software-owned clock is off, and the reset words read back as the present masks (group 0 0x1778, group 1 0x0067, group 2 0x01F3).
- R2: A write to address 0 with a valid code sets that peripheral's clock enable, visible on the output and status word from the cycle after the write. Code format: bits [15:8] zero, bits [7:4] group (0..2), bits [3:0] bit index within the group.
- R3: A write of a valid code to address 1 clears that peripheral's clock enable from the cycle after the write.
- R4: Hardware-owned slots (group 0 bits 3,4,8,10; group 1 bit 0; group 2 bit 0) ignore set and clear writes, and their enable equals the matching `hw_clk_req` bit.
- R5: The code 0xFFFF, codes with a non-zero upper byte, codes for group 3 or above, and codes that point at an absent slot change no state.
- R6: The console UART (group 2 bit 1, code 0x0021) ignores clear writes; set writes enable it.
- R7: Once the console UART reset bit has been cleared, later writes cannot set it again until the block reset.
- R8: The slots with no enable control (group 0 bit 12, group 2 bit 6) always have their enable output high and read back enabled.
- R9: A write to a reset word (addresses 5, 6, 7 for groups 0, 1, 2) loads its bits: 1 holds that peripheral in reset, 0 releases it. Bits of absent slots read 0. Reset writes do not change clock enables.
- R10: Reads of addresses 0 and 1 return zero. Addresses 2, 3 and 4 return the enable status of groups 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| hw_clk_req | input | 48 | Hardware clock requests, one per slot |
| clk_en_o | output | 48 | Clock enable per slot |
| rst_o | output | 48 | Reset per slot, active high |

## Verification
A wrong software-enable or reset bit shows on `clk_en_o` or `rst_o` in the cycle after the write that caused it, so the bench compares both full vectors against its model on every clock. A lost console lock appears only when a later write tries to re-assert or gate the UART, which the bench provokes on purpose. Decode faults that hit the wrong slot or let a reserved code through show at once as a stray enable bit in an unrelated group.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int GRP_W  = 16;
  localparam int N_GRP  = 3;
  localparam int N_SLOT = GRP_W * N_GRP;
  localparam int CODE_W = 16;

  typedef enum logic [2:0] {
    A_SET  = 3'd0,
    A_CLR  = 3'd1,
    A_ST0  = 3'd2,
    A_ST1  = 3'd3,
    A_ST2  = 3'd4,
    A_RS0  = 3'd5,
    A_RS1  = 3'd6,
    A_RS2  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pgc_code_dec.sv
module pgc_code_dec #(
  parameter int GW     = 16,
  parameter int NG     = 3,
  parameter int CW     = 16,
  parameter logic [GW*NG-1:0] PRESENT = '0
) (
  input  logic [CW-1:0]    code,
  output logic [GW*NG-1:0] sel
);
  localparam int IW = $clog2(GW);
  localparam int GF = 4;

  logic [GF-1:0] grp;
  logic [IW-1:0] idx;
  logic          upper_zero;
  logic [GW*NG-1:0] raw;

  assign grp        = code[IW +: GF];
  assign idx        = code[IW-1:0];
  assign upper_zero = (code[CW-1:IW+GF] == '0);

  always_comb begin
    raw = '0;
    if (upper_zero && (int'(grp) < NG)) begin
      raw[int'(grp) * GW + int'(idx)] = 1'b1;
    end
    sel = raw & PRESENT;
  end
endmodule

// File: rtl/pgc_gate_bank.sv
module pgc_gate_bank #(
  parameter int N = 48,
  parameter logic [N-1:0] PRESENT   = '0,
  parameter logic [N-1:0] HW_OWNED  = '0,
  parameter logic [N-1:0] ALWAYS_ON = '0,
  parameter int CONSOLE = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_sel,
  input  logic [N-1:0] clr_sel,
  input  logic [N-1:0] hw_req,
  output logic [N-1:0] en
);
  localparam logic [N-1:0] SW_OWNED = PRESENT & ~HW_OWNED & ~ALWAYS_ON;
  localparam logic [N-1:0] NO_CLEAR = N'(1) << CONSOLE;

  logic [N-1:0] sw_q, sw_d;
  logic         upd;

  assign upd = |(set_sel | clr_sel);

  always_comb begin
    sw_d = sw_q;
    sw_d = sw_d | (set_sel & SW_OWNED);
    sw_d = sw_d & ~(clr_sel & SW_OWNED & ~NO_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sw_q <= '0;
    else if (upd) sw_q <= sw_d;
  end

  assign en = PRESENT & (ALWAYS_ON | (HW_OWNED & ~ALWAYS_ON & hw_req) | (SW_OWNED & sw_q));
endmodule

// File: rtl/pgc_reset_bank.sv
module pgc_reset_bank #(
  parameter int GW = 16,
  parameter int NG = 3,
  parameter logic [GW*NG-1:0] PRESENT = '0,
  parameter int CONSOLE = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NG-1:0]    wr_grp,
  input  logic [GW-1:0]    wdata,
  output logic [GW*NG-1:0] rst_q
);
  localparam int N = GW * NG;
  localparam logic [N-1:0] LOCK_BIT = N'(1) << CONSOLE;

  logic [N-1:0] load, rst_d;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign load[g*GW +: GW] = wr_grp[g] ? (wdata & PRESENT[g*GW +: GW])
                                        : rst_q[g*GW +: GW];
  end

  // a released console reset stays released
  assign rst_d = load & ~(LOCK_BIT & ~rst_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rst_q <= PRESENT;
    else if (|wr_grp) rst_q <= rst_d;
  end
endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl
  import pgc_pkg::*;
#(
  parameter logic [N_SLOT-1:0] PRESENT   = 48'h01F3_0067_1778,
  parameter logic [N_SLOT-1:0] HW_OWNED  = 48'h0041_0001_0518,
  parameter logic [N_SLOT-1:0] ALWAYS_ON = 48'h0040_0000_1000,
  parameter int CONSOLE = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [N_SLOT-1:0] hw_clk_req,
  output logic [N_SLOT-1:0] clk_en_o,
  output logic [N_SLOT-1:0] rst_o
);
  logic [N_SLOT-1:0] code_sel, set_sel, clr_sel;
  logic [N_GRP-1:0]  rst_wr;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(reg_addr);

  pgc_code_dec #(.GW(GRP_W), .NG(N_GRP), .CW(CODE_W), .PRESENT(PRESENT)) u_dec (
    .code (reg_wdata),
    .sel  (code_sel)
  );

  assign set_sel = (reg_we && addr == A_SET) ? code_sel : '0;
  assign clr_sel = (reg_we && addr == A_CLR) ? code_sel : '0;

  pgc_gate_bank #(.N(N_SLOT), .PRESENT(PRESENT), .HW_OWNED(HW_OWNED),
                  .ALWAYS_ON(ALWAYS_ON), .CONSOLE(CONSOLE)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_sel (set_sel),
    .clr_sel (clr_sel),
    .hw_req  (hw_clk_req),
    .en      (clk_en_o)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_rwr
    assign rst_wr[g] = reg_we && (int'(reg_addr) == int'(A_RS0) + g);
  end

  pgc_reset_bank #(.GW(GRP_W), .NG(N_GRP), .PRESENT(PRESENT), .CONSOLE(CONSOLE)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_grp (rst_wr),
    .wdata  (reg_wdata),
    .rst_q  (rst_o)
  );

  always_comb begin
    unique case (addr)
      A_ST0:   reg_rdata = clk_en_o[0*GRP_W +: GRP_W];
      A_ST1:   reg_rdata = clk_en_o[1*GRP_W +: GRP_W];
      A_ST2:   reg_rdata = clk_en_o[2*GRP_W +: GRP_W];
      A_RS0:   reg_rdata = rst_o[0*GRP_W +: GRP_W];
      A_RS1:   reg_rdata = rst_o[1*GRP_W +: GRP_W];
      A_RS2:   reg_rdata = rst_o[2*GRP_W +: GRP_W];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/periph_gate_ctrl_chk.sv
module periph_gate_ctrl_chk #(
  parameter logic [47:0] PRESENT   = '0,
  parameter logic [47:0] HW_OWNED  = '0,
  parameter logic [47:0] ALWAYS_ON = '0,
  parameter int CONSOLE = 33
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic [47:0] hw_clk_req,
  input logic [47:0] clk_en_o,
  input logic [47:0] rst_o
);
  localparam logic [15:0] CON_CODE = 16'(((CONSOLE / 16) << 4) | (CONSOLE % 16));
  localparam logic [47:0] SW_BITS  = PRESENT & ~HW_OWNED & ~ALWAYS_ON;

  // R7: released console reset never comes back
  a_r7_console_rst_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_o[CONSOLE] |=> !rst_o[CONSOLE]);

  // R6: console clock survives a clear write
  a_r6_console_no_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && reg_wdata == CON_CODE && clk_en_o[CONSOLE])
    |=> clk_en_o[CONSOLE]);

  // R8: slots without enable control stay enabled
  a_r8_always_on: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o & ALWAYS_ON) == ALWAYS_ON);

  // R2: software enables move only on set/clear writes
  a_r2_sw_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == 3'd0 || reg_addr == 3'd1))
    |=> $stable(clk_en_o & SW_BITS));

  // R9: absent slots never enabled nor in reset
  a_r9_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_en_o | rst_o) & ~PRESENT) == '0);

  // R10: code registers read zero
  a_r10_code_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr <= 3'd1) |-> reg_rdata == '0);
endmodule

bind periph_gate_ctrl periph_gate_ctrl_chk #(
  .PRESENT(PRESENT), .HW_OWNED(HW_OWNED), .ALWAYS_ON(ALWAYS_ON), .CONSOLE(CONSOLE)
) u_chk (.*);

// File: tb/periph_gate_ctrl_tb.sv
module periph_gate_ctrl_tb;
  localparam logic [47:0] P_MASK  = 48'h01F3_0067_1778;
  localparam logic [47:0] H_MASK  = 48'h0041_0001_0518;
  localparam logic [47:0] AO_MASK = 48'h0040_0000_1000;
  localparam int CON = 33;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [47:0] hw_clk_req;
  logic [47:0] clk_en_o;
  logic [47:0] rst_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  periph_gate_ctrl u_dut (.*);

  // behavioural model
  bit m_sw  [48];
  bit m_rst [48];

  function automatic int code_slot(input logic [15:0] c);
    if (c[15:8] != 0 || c[7:4] > 2) return -1;
    if (!P_MASK[c[7:4]*16 + c[3:0]]) return -1;
    return c[7:4]*16 + c[3:0];
  endfunction

  function automatic logic [47:0] m_clk();
    logic [47:0] v;
    for (int i = 0; i < 48; i++) begin
      if (!P_MASK[i])       v[i] = 0;
      else if (AO_MASK[i])  v[i] = 1;
      else if (H_MASK[i])   v[i] = hw_clk_req[i];
      else                  v[i] = m_sw[i];
    end
    return v;
  endfunction

  function automatic logic [47:0] m_rstv();
    logic [47:0] v;
    for (int i = 0; i < 48; i++) v[i] = m_rst[i];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 48; i++) begin m_sw[i] = 0; m_rst[i] = P_MASK[i]; end
    end else if (reg_we) begin
      int s;
      s = code_slot(reg_wdata);
      if (reg_addr == 0 && s >= 0 && !H_MASK[s] && !AO_MASK[s]) m_sw[s] = 1;
      if (reg_addr == 1 && s >= 0 && !H_MASK[s] && !AO_MASK[s] && s != CON) m_sw[s] = 0;
      if (reg_addr >= 5) begin
        for (int b = 0; b < 16; b++) begin
          int k;
          k = (reg_addr - 5) * 16 + b;
          if (!(k == CON && !m_rst[k])) m_rst[k] = reg_wdata[b] & P_MASK[k];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison, away from both edges
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check(clk_en_o == m_clk(), "R2 R3 R4 clk_en model", clk_en_o, m_clk());
      check(rst_o == m_rstv(),   "R1 R7 R9 rst model",    rst_o,    m_rstv());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = 16'h0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(reg_rdata == exp, req, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; hw_clk_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd5, 16'h1778, "R1 rst g0");
    rd(3'd6, 16'h0067, "R1 rst g1");
    rd(3'd7, 16'h01F3, "R1 rst g2");
    rd(3'd3, 16'h0000, "R1 status g1 off");
    // R8 always-on slots
    rd(3'd2, 16'h1000, "R8 status g0");
    rd(3'd4, 16'h0040, "R8 status g2");
    // R2 set
    wr(3'd0, 16'h0006); wr(3'd0, 16'h0011); wr(3'd0, 16'h0024); wr(3'd0, 16'h0021);
    rd(3'd2, 16'h1040, "R2 nand on");
    rd(3'd3, 16'h0002, "R2 fast i2c on");
    rd(3'd4, 16'h0052, "R2 slow gpio+console on");
    // R3 clear
    wr(3'd1, 16'h0006);
    rd(3'd2, 16'h1000, "R3 nand off");
    // R6 console ignores clear
    wr(3'd1, 16'h0021);
    rd(3'd4, 16'h0052, "R6 console stays on");
    // R4 hardware-owned
    wr(3'd0, 16'h0003);
    rd(3'd2, 16'h1000, "R4 sw set ignored");
    hw_clk_req[3] = 1;
    rd(3'd2, 16'h1008, "R4 follows hw req");
    wr(3'd1, 16'h0003);
    rd(3'd2, 16'h1008, "R4 sw clear ignored");
    hw_clk_req[3] = 0;
    rd(3'd2, 16'h1000, "R4 hw req drop");
    hw_clk_req = 48'hFFFF_FFFF_FFFF;
    rd(3'd3, 16'h0003, "R4 fast bridge hw on");
    hw_clk_req = '0;
    // R5 ignored codes
    wr(3'd0, 16'hFFFF); wr(3'd0, 16'h0030); wr(3'd0, 16'h0107); wr(3'd0, 16'h0007);
    wr(3'd1, 16'hFFFF); wr(3'd1, 16'h0111);
    rd(3'd2, 16'h1000, "R5 g0 unchanged");
    rd(3'd3, 16'h0002, "R5 g1 unchanged");
    rd(3'd4, 16'h0052, "R5 g2 unchanged");
    // R8 clear of always-on
    wr(3'd1, 16'h000C);
    rd(3'd2, 16'h1000, "R8 intcon stays on");
    // R9 reset words
    wr(3'd7, 16'h0000);
    rd(3'd7, 16'h0000, "R9 slow released");
    rd(3'd4, 16'h0052, "R9 clocks untouched");
    // R7 console lock
    wr(3'd7, 16'hFFFF);
    rd(3'd7, 16'h01F1, "R7 console stays released");
    wr(3'd5, 16'h0000); wr(3'd5, 16'hFFFF);
    rd(3'd5, 16'h1778, "R9 g0 reassert");
    wr(3'd6, 16'h0042);
    rd(3'd6, 16'h0042, "R9 g1 partial");
    // R10 code regs read zero
    rd(3'd0, 16'h0000, "R10 set reads zero");
    rd(3'd1, 16'h0000, "R10 clr reads zero");
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule